// File: doc/BRIEF.md
# Half-Duplex Synchronous Programming Link

This block is the target-side physical layer of a two-wire programming port. An external programmer supplies the clock and shares one data line with the target. The block receives and sends fixed-length characters on that line. It checks the parity of each character it receives. It watches for both ends driving the line at once. When the link turns from listening to talking, it holds the line idle for a selectable number of bit times before the first character goes out.

Characters pass to and from an access layer one byte at a time. The access layer asks for the direction of transfer, hands over bytes to send, takes received bytes on a one-cycle strobe, and reads two sticky error flags. After an error the block stays silent and ignores the line until the access layer clears the error. Only the access layer can clear it.

Top module: `hdx_prog_phy`

## Requirements
- R1: A sent character is 12 bits wide. It starts with a low start bit, then the eight data bits least significant bit first, then an even parity bit (the XOR of the data bits), then two high stop bits. Each bit is placed on `pin_out` at a falling clock edge and `pin_oe` is high while it is driven.
- R2: In receive direction the line is sampled on rising edges, and a low sample while idle marks a start bit. One cycle after the rising edge that samples the second stop bit, `rx_valid` is high for exactly one cycle and `rx_data` holds the byte.
- R3: If the sampled parity bit differs from the XOR of the received data bits, `err_parity` is high right after that rising edge. It stays high, and no further `rx_valid` is produced, until the error is cleared.
- R4: While the block drives the line, a rising-edge sample of `pin_in` that differs from `pin_out` sets `err_collision`, and `pin_oe` is low from that same edge on.
- R5: When `dir_tx` is first seen high on a rising edge while receiving and idle, the block drives the line high for 128 >> `guard_sel` bit times. `guard_sel` 0..7 gives 128, 64, 32, 16, 8, 4, 2 or 1. `tx_ready` rises exactly that many rising edges later.
- R6: When `dir_tx` is seen low on a rising edge while sending and idle, `pin_oe` is low after the next falling edge. No guard time is added, and a character starting on the next bit is received.
- R7: A rising edge with `err_clear` high while in the error state clears both error flags and returns the block to receive direction.
- R8: `tx_valid` has no effect unless `tx_ready` is high. In receive direction the line stays undriven.
- R9: After reset `pin_oe`, `tx_ready`, `rx_valid`, `err_parity` and `err_collision` are all low.
- R10: `tx_ready` drops on the rising edge that accepts a byte and rises again 12 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock supplied by the programmer |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 1 | Value read from the data line |
| pin_out | output | 1 | Value driven onto the data line |
| pin_oe | output | 1 | Drive enable for the data line |
| dir_tx | input | 1 | Direction request: 1 send, 0 receive |
| guard_sel | input | 3 | Turnaround guard length select |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Send request, taken when tx_ready is high |
| tx_ready | output | 1 | Ready to accept a byte to send |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| err_clear | input | 1 | Clears the error state |
| err_parity | output | 1 | Sticky parity error flag |
| err_collision | output | 1 | Sticky drive collision flag |

## Verification
Received bytes and parity errors show up one cycle after the rising edge that samples the second stop bit or the parity bit. The bench drives each line bit just after a falling edge and reads those flags just after the matching rising edge. Sent bits change at falling edges, so the bench reads them just after each falling edge that follows the accepting edge. It expects `tx_ready` back exactly 12 rising edges later. Guard length is checked by counting rising edges from the one that sees `dir_tx`, with a check one edge before and one at the expected edge. A collision is checked just after the rising edge that samples the forced line.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  localparam int GSEL_W     = 3;
  localparam int GUARD_LOG2 = 7;
  localparam int GCNT_W     = GUARD_LOG2 + 1;

  typedef enum logic [1:0] {
    LS_RECV  = 2'd0,
    LS_GUARD = 2'd1,
    LS_SEND  = 2'd2,
    LS_FAULT = 2'd3
  } link_state_t;

  // idle bit times inserted on a listen-to-talk turnaround
  function automatic logic [GCNT_W-1:0] guard_bits(input logic [GSEL_W-1:0] sel);
    logic [GCNT_W-1:0] base;
    base = GCNT_W'(1) << GUARD_LOG2;
    return base >> sel;
  endfunction

endpackage

// File: rtl/hdx_rx.sv
module hdx_rx #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              line_i,
  output logic              busy_o,
  output logic              par_bad_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int LAST  = DATA_W + STOP_BITS;
  localparam int CNT_W = $clog2(LAST + 1);

  logic [CNT_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              bit_is_data;
  logic              bit_is_par;
  logic              bit_is_last;

  assign bit_is_data = busy_o && (idx < CNT_W'(DATA_W));
  assign bit_is_par  = busy_o && (idx == CNT_W'(DATA_W));
  assign bit_is_last = busy_o && (idx == CNT_W'(LAST));
  assign par_bad_o   = en && bit_is_par && (line_i != (^shreg));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en) begin
        busy_o <= 1'b0;
        idx    <= '0;
      end else if (!busy_o) begin
        if (!line_i) begin
          busy_o <= 1'b1;
          idx    <= '0;
        end
      end else begin
        idx <= idx + 1'b1;
        if (bit_is_data) begin
          shreg <= {line_i, shreg[DATA_W-1:1]};
        end else if (par_bad_o) begin
          busy_o <= 1'b0;
        end else if (bit_is_last) begin
          valid_o <= 1'b1;
          data_o  <= shreg;
          busy_o  <= 1'b0;
        end
      end
    end
  end

  // R2: a received byte is announced for one cycle only
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

endmodule

// File: rtl/hdx_tx.sv
module hdx_tx #(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              bit_o
);
  localparam int FRAME_BITS = DATA_W + 2 + STOP_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      cnt;
  logic                  take;

  // stop bits high, even parity, data LSB first, start bit low
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {{STOP_BITS{1'b1}}, ^d, d, 1'b0};
  endfunction

  assign take  = en && load_i && !busy_o;
  assign bit_o = busy_o ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame  <= '1;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (!en) begin
      frame  <= '1;
      cnt    <= '0;
      busy_o <= 1'b0;
    end else if (take) begin
      frame  <= build_frame(data_i);
      cnt    <= CNT_W'(FRAME_BITS - 1);
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == '0) begin
        busy_o <= 1'b0;
      end else begin
        cnt   <= cnt - 1'b1;
        frame <= {1'b1, frame[FRAME_BITS-1:1]};
      end
    end
  end

  // R8: a frame only starts while the sender is enabled
  p_load_in_send_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(en));

endmodule

// File: rtl/hdx_ctrl.sv
module hdx_ctrl
  import hdx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_tx,
  input  logic [GSEL_W-1:0] guard_sel,
  input  logic              rx_busy,
  input  logic              par_bad,
  input  logic              tx_busy,
  input  logic              coll_now,
  input  logic              err_clear,
  output link_state_t       state_o,
  output logic              err_parity_o,
  output logic              err_coll_o
);
  logic [GCNT_W-1:0] gcnt;
  logic              driving;

  assign driving = (state_o == LS_GUARD) || (state_o == LS_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o      <= LS_RECV;
      gcnt         <= '0;
      err_parity_o <= 1'b0;
      err_coll_o   <= 1'b0;
    end else begin
      unique case (state_o)
        LS_RECV: begin
          if (par_bad) begin
            state_o      <= LS_FAULT;
            err_parity_o <= 1'b1;
          end else if (dir_tx && !rx_busy) begin
            state_o <= LS_GUARD;
            gcnt    <= guard_bits(guard_sel) - 1'b1;
          end
        end
        LS_GUARD: begin
          if (coll_now) begin
            state_o    <= LS_FAULT;
            err_coll_o <= 1'b1;
          end else if (!dir_tx) begin
            state_o <= LS_RECV;
          end else if (gcnt == '0) begin
            state_o <= LS_SEND;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        LS_SEND: begin
          if (coll_now) begin
            state_o    <= LS_FAULT;
            err_coll_o <= 1'b1;
          end else if (!dir_tx && !tx_busy) begin
            state_o <= LS_RECV;
          end
        end
        LS_FAULT: begin
          if (err_clear) begin
            state_o      <= LS_RECV;
            err_parity_o <= 1'b0;
            err_coll_o   <= 1'b0;
          end
        end
        default: state_o <= LS_RECV;
      endcase
    end
  end

  // R3: a parity error stays until it is cleared
  p_parity_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity_o && !err_clear) |=> err_parity_o);

  // R7: the error state is left only through err_clear
  p_fault_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == LS_FAULT && !err_clear) |=> (state_o == LS_FAULT));

  // R5: sending is never reached without a guard period
  p_send_after_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == LS_SEND) |-> ($past(state_o) != LS_RECV));

  // R4: a mismatch seen while driving always ends in a collision flag
  p_coll_to_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_now && driving) |=> err_coll_o);

endmodule

// File: rtl/hdx_prog_phy.sv
module hdx_prog_phy
  import hdx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  input  logic              dir_tx,
  input  logic [GSEL_W-1:0] guard_sel,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              err_clear,
  output logic              err_parity,
  output logic              err_collision
);
  link_state_t state;
  logic        rx_busy;
  logic        par_bad;
  logic        tx_busy;
  logic        tx_bit;
  logic        coll_now;
  logic        drive_next;
  logic        drv_oe_q;
  logic        drv_out_q;

  hdx_rx #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state == LS_RECV),
    .line_i    (pin_in),
    .busy_o    (rx_busy),
    .par_bad_o (par_bad),
    .data_o    (rx_data),
    .valid_o   (rx_valid)
  );

  hdx_tx #(.DATA_W(DATA_W), .STOP_BITS(STOP_BITS)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (state == LS_SEND),
    .load_i (tx_valid),
    .data_i (tx_data),
    .busy_o (tx_busy),
    .bit_o  (tx_bit)
  );

  hdx_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_tx       (dir_tx),
    .guard_sel    (guard_sel),
    .rx_busy      (rx_busy),
    .par_bad      (par_bad),
    .tx_busy      (tx_busy),
    .coll_now     (coll_now),
    .err_clear    (err_clear),
    .state_o      (state),
    .err_parity_o (err_parity),
    .err_coll_o   (err_collision)
  );

  assign drive_next = (state == LS_GUARD) || (state == LS_SEND);
  assign coll_now   = drv_oe_q && (pin_in != drv_out_q);

  // line changes on the falling edge, half a bit before the sample
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_oe_q  <= 1'b0;
      drv_out_q <= 1'b1;
    end else begin
      drv_oe_q  <= drive_next;
      drv_out_q <= tx_bit;
    end
  end

  assign pin_out  = drv_out_q;
  assign pin_oe   = drv_oe_q && (state != LS_FAULT);
  assign tx_ready = (state == LS_SEND) && !tx_busy;

  // R4: the driver is off whenever a collision is flagged
  p_oe_off_in_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_collision |-> !pin_oe);

  // R6: the line is released whenever the link listens
  p_quiet_in_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_RECV) |-> !pin_oe);

endmodule

// File: tb/hdx_prog_phy_bench.sv
module hdx_prog_phy_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in;
  logic       pin_out;
  logic       pin_oe;
  logic       dir_tx = 1'b0;
  logic [2:0] guard_sel = 3'd0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       err_clear = 1'b0;
  logic       err_parity;
  logic       err_collision;

  logic host_oe = 1'b0;
  logic host_val = 1'b1;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // shared line: the programmer overrides, otherwise target or pull-up
  assign pin_in = host_oe ? host_val : (pin_oe ? pin_out : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  hdx_prog_phy u_hdx_prog_phy (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .dir_tx(dir_tx), .guard_sel(guard_sel), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .err_clear(err_clear),
    .err_parity(err_parity), .err_collision(err_collision)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] frame_of(input logic [7:0] d, input bit flip);
    return {2'b11, (^d) ^ flip, d, 1'b0};
  endfunction

  // programmer sends one character; flip corrupts the parity bit
  task automatic host_frame(input logic [7:0] d, input bit flip,
                            output bit par_seen, output bit vld, output logic [7:0] dat,
                            output bit early);
    logic [11:0] fr = frame_of(d, flip);
    early = 0; par_seen = 0; vld = 0; dat = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      host_oe = 1'b1; host_val = fr[i];
      @(posedge clk); #1;
      if (i == 9) par_seen = err_parity;
      if (i < 11 && rx_valid) early = 1;
      if (i == 11) begin vld = rx_valid; dat = rx_data; end
    end
    @(negedge clk); #1;
    host_oe = 1'b0; host_val = 1'b1;
  endtask

  task automatic rx_good(input logic [7:0] d);
    bit p, v, e; logic [7:0] q;
    host_frame(d, 0, p, v, q, e);
    chk("R2 rx_valid", v, 1);
    chk("R2 rx_data", q, d);
    chk("R2 no early strobe", e, 0);
    chk("R3 no parity error", p, 0);
  endtask

  task automatic go_tx(input logic [2:0] sel, input int n);
    @(negedge clk); #1;
    guard_sel = sel; dir_tx = 1'b1;
    @(posedge clk);
    if (n > 1) begin
      repeat (n - 1) @(posedge clk);
      #1;
      chk("R5 not ready one edge early", tx_ready, 0);
      chk("R5 guard drives", pin_oe, 1);
      chk("R5 guard idle high", pin_out, 1);
    end
    @(posedge clk); #1;
    chk("R5 ready after guard", tx_ready, 1);
  endtask

  task automatic go_rx();
    @(negedge clk); #1;
    dir_tx = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    chk("R6 line released", pin_oe, 0);
  endtask

  task automatic tx_byte(input logic [7:0] d);
    logic [11:0] exp = frame_of(d, 0);
    logic [11:0] got = '0;
    bit oe_ok = 1;
    chk("R10 ready before load", tx_ready, 1);
    @(negedge clk); #1;
    tx_valid = 1'b1; tx_data = d;
    @(posedge clk);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      if (i == 0) begin
        tx_valid = 1'b0;
        chk("R10 busy after load", tx_ready, 0);
      end
      got[i] = pin_out;
      if (!pin_oe) oe_ok = 0;
    end
    chk("R1 frame bits", got, exp);
    chk("R1 driven throughout", oe_ok, 1);
    @(posedge clk); #1;
    chk("R10 ready after 12 edges", tx_ready, 1);
  endtask

  task automatic clear_err();
    @(negedge clk); #1;
    host_oe = 1'b0; dir_tx = 1'b0; err_clear = 1'b1;
    @(posedge clk); #1;
    chk("R7 parity flag cleared", err_parity, 0);
    chk("R7 collision flag cleared", err_collision, 0);
    @(negedge clk); #1;
    err_clear = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    chk("R9 oe", pin_oe, 0);
    chk("R9 ready", tx_ready, 0);
    chk("R9 valid", rx_valid, 0);
    chk("R9 parity", err_parity, 0);
    chk("R9 collision", err_collision, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9 oe after release", pin_oe, 0);
  endtask

  task automatic t_ignore_in_rx();
    @(negedge clk); #1;
    tx_valid = 1'b1; tx_data = 8'h55;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R8 no drive in receive", pin_oe, 0);
    chk("R8 not ready in receive", tx_ready, 0);
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 still quiet", pin_oe, 0);
  endtask

  task automatic t_parity();
    bit p, v, e; logic [7:0] q;
    host_frame(8'h77, 1, p, v, q, e);
    chk("R3 parity flag after parity bit", p, 1);
    chk("R3 no strobe on bad frame", v, 0);
    host_frame(8'h12, 0, p, v, q, e);
    chk("R3 frames ignored in error", v | e, 0);
    chk("R3 flag sticky", err_parity, 1);
    clear_err();
    rx_good(8'h34);
  endtask

  task automatic t_coll_idle();
    go_tx(3'd6, 2);
    @(negedge clk); #1;
    host_oe = 1'b1; host_val = 1'b0;
    @(posedge clk); #1;
    chk("R4 collision flag idle", err_collision, 1);
    chk("R4 oe dropped idle", pin_oe, 0);
    clear_err();
  endtask

  task automatic t_coll_frame();
    go_tx(3'd6, 2);
    @(negedge clk); #1;
    tx_valid = 1'b1; tx_data = 8'hF0;
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (i == 0) tx_valid = 1'b0;
    end
    @(negedge clk); #1;
    chk("R1 data bit 4 driven high", pin_out, 1);
    host_oe = 1'b1; host_val = 1'b0;
    @(posedge clk); #1;
    chk("R4 collision flag in frame", err_collision, 1);
    chk("R4 oe dropped in frame", pin_oe, 0);
    clear_err();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    rx_good(8'hA5);
    rx_good(8'h3C);
    rx_good(8'h00);
    rx_good(8'hFF);
    t_ignore_in_rx();
    go_tx(3'd6, 2);
    tx_byte(8'h96);
    tx_byte(8'h01);
    go_rx();
    rx_good(8'h5A);
    go_tx(3'd3, 16);
    tx_byte(8'hC3);
    go_rx();
    go_tx(3'd0, 128);
    go_rx();
    go_tx(3'd7, 1);
    go_rx();
    t_parity();
    t_coll_idle();
    t_coll_frame();
    rx_good(8'h81);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule